// File: doc/BRIEF.md
# Signed Multiply-Accumulate Unit

This block multiplies two signed operands and folds the product into a wide accumulator register. Each rising clock edge the register can take the accumulator plus the product or the accumulator minus the product. When the load path is built in, it can instead take the bare product, which starts a new sum. The accumulator output is fed straight back as the second operand of the adder/subtractor, so a stream of operand pairs becomes a running sum of products.

Parameters fix the structure of each instance. The first is whether the load multiplexer exists. The second is which of four register flavours is built: bare, with an asynchronous clear, with a clock enable, or with both. The third is whether the `result` port shows the registered accumulator or the combinational value about to be captured. Products are sign-extended to the accumulator width, and the sum wraps modulo 2^ACC_W with no saturation.

Top module: `macc_core`

## Requirements
- R1: With the load multiplexer built and `load`=1, the register captures the signed product of `op_a` and `op_b`, sign-extended to ACC_W bits, on the next rising edge.
- R2: With `load`=0 (or no load multiplexer) and `sub`=0, the register captures the accumulator plus the sign-extended product.
- R3: With `load`=0 (or no load multiplexer) and `sub`=1, the register captures the accumulator minus the sign-extended product.
- R4: Accumulation wraps modulo 2^ACC_W. Adding 2^30 to the accumulator 512 times from zero gives 40'h80_0000_0000, and subtracting 1 from zero gives 40'hFF_FFFF_FFFF.
- R5: In the reset-capable flavours, `rst`=1 (active high) clears the accumulator to zero at once, without waiting for a clock edge and whatever the value of `en`.
- R6: In the enable-capable flavours, `en`=0 keeps the accumulator unchanged across clock edges, whatever `load`, `sub` and the operands are.
- R7: With the registered tap, `result` equals the accumulator register and changes only at a rising clock edge, not when the inputs change between edges.
- R8: With the combinational tap, `result` equals the value the register would capture on the next edge: the product if `load`=1, otherwise the accumulator plus or minus the product.
- R9: Without the load multiplexer, `load` has no effect and every enabled edge accumulates.
- R10: A flavour without reset ignores `rst`, and a flavour without enable ignores `en`; both then update on every rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the register captures on the rising edge |
| rst | input | 1 | Asynchronous clear, active high (reset flavours only) |
| en | input | 1 | Clock enable, active high (enable flavours only) |
| load | input | 1 | 1: start a new sum with the product; 0: accumulate |
| sub | input | 1 | 1: subtract the product; 0: add it |
| op_a | input | OP_W | Signed multiplicand |
| op_b | input | OP_W | Signed multiplier |
| result | output | ACC_W | Registered accumulator or combinational next value, per COMB_TAP |

## Verification
The hardest state to reach from the ports is the wrap-around of the 40-bit accumulator. The largest product of two 16-bit operands is only 2^30, so the bench loads that product and then adds it 511 more times to cross 2^39, then checks the exact wrapped pattern. It also reaches the borrow case by loading a zero product and subtracting one. The asynchronous clear is checked between clock edges, with the enable low, so that the clearing can only come from the reset path.

// File: rtl/macc_pkg.sv
package macc_pkg;

    localparam int unsigned OP_W_DEF  = 16;
    localparam int unsigned ACC_W_DEF = 40;

    typedef enum logic [1:0] {
        REG_PLAIN   = 2'd0,
        REG_ARST    = 2'd1,
        REG_EN      = 2'd2,
        REG_ARST_EN = 2'd3
    } acc_reg_kind_e;

    typedef struct packed {
        logic load;
        logic sub;
        logic en;
    } macc_ctrl_t;

    function automatic logic kind_has_rst(acc_reg_kind_e k);
        return (k == REG_ARST) || (k == REG_ARST_EN);
    endfunction

    function automatic logic kind_has_en(acc_reg_kind_e k);
        return (k == REG_EN) || (k == REG_ARST_EN);
    endfunction

endpackage

// File: rtl/macc_mult.sv
module macc_mult #(
    parameter int unsigned OP_W   = macc_pkg::OP_W_DEF,
    localparam int unsigned PROD_W = 2 * OP_W
) (
    input  logic [OP_W-1:0]   a,
    input  logic [OP_W-1:0]   b,
    output logic [PROD_W-1:0] prod
);
    logic signed [PROD_W-1:0] prod_s;

    always_comb begin
        prod_s = $signed(a) * $signed(b);
    end

    assign prod = prod_s;
endmodule

// File: rtl/macc_addsub.sv
module macc_addsub #(
    parameter int unsigned ACC_W = macc_pkg::ACC_W_DEF
) (
    input  logic [ACC_W-1:0] acc,
    input  logic [ACC_W-1:0] prod_ext,
    input  logic             sub,
    output logic [ACC_W-1:0] sum
);
    always_comb begin
        if (sub) begin
            sum = acc - prod_ext;
        end else begin
            sum = acc + prod_ext;
        end
    end
endmodule

// File: rtl/macc_loadsel.sv
module macc_loadsel #(
    parameter int unsigned ACC_W        = macc_pkg::ACC_W_DEF,
    parameter bit          HAS_LOAD_MUX = 1'b1
) (
    input  logic             load,
    input  logic [ACC_W-1:0] prod_ext,
    input  logic [ACC_W-1:0] sum,
    output logic [ACC_W-1:0] next_val
);
    generate
        if (HAS_LOAD_MUX) begin : g_mux
            assign next_val = load ? prod_ext : sum;
        end else begin : g_thru
            logic unused_sel;
            assign unused_sel = ^{load, prod_ext};
            assign next_val   = sum;
        end
    endgenerate
endmodule

// File: rtl/macc_accreg.sv
module macc_accreg #(
    parameter int unsigned             ACC_W    = macc_pkg::ACC_W_DEF,
    parameter macc_pkg::acc_reg_kind_e REG_KIND = macc_pkg::REG_ARST_EN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [ACC_W-1:0] d,
    output logic [ACC_W-1:0] q
);
    import macc_pkg::*;

    generate
        case (REG_KIND)
            REG_PLAIN: begin : g_plain
                logic unused_ctl;
                assign unused_ctl = ^{rst, en};
                always_ff @(posedge clk) begin
                    q <= d;
                end
            end
            REG_ARST: begin : g_arst
                logic unused_ctl;
                assign unused_ctl = en;
                always_ff @(posedge clk or posedge rst) begin
                    if (rst) q <= '0;
                    else     q <= d;
                end
            end
            REG_EN: begin : g_en
                logic unused_ctl;
                assign unused_ctl = rst;
                always_ff @(posedge clk) begin
                    if (en) q <= d;
                end
            end
            default: begin : g_arst_en
                always_ff @(posedge clk or posedge rst) begin
                    if (rst)     q <= '0;
                    else if (en) q <= d;
                end
            end
        endcase
    endgenerate
endmodule

// File: rtl/macc_core.sv
module macc_core #(
    parameter int unsigned             OP_W         = macc_pkg::OP_W_DEF,
    parameter int unsigned             ACC_W        = macc_pkg::ACC_W_DEF,
    parameter bit                      HAS_LOAD_MUX = 1'b1,
    parameter macc_pkg::acc_reg_kind_e REG_KIND     = macc_pkg::REG_ARST_EN,
    parameter bit                      COMB_TAP     = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             load,
    input  logic             sub,
    input  logic [OP_W-1:0]  op_a,
    input  logic [OP_W-1:0]  op_b,
    output logic [ACC_W-1:0] result
);
    import macc_pkg::*;

    localparam int unsigned PROD_W = 2 * OP_W;
    localparam int unsigned EXT_W  = ACC_W - PROD_W;

    macc_ctrl_t       ctrl;
    logic [PROD_W-1:0] prod;
    logic [ACC_W-1:0]  prod_ext;
    logic [ACC_W-1:0]  sum_val;
    logic [ACC_W-1:0]  next_val;
    logic [ACC_W-1:0]  acc_q;

    assign ctrl = '{load: load, sub: sub, en: en};

    macc_mult #(.OP_W(OP_W)) u_mult (
        .a    (op_a),
        .b    (op_b),
        .prod (prod)
    );

    generate
        if (EXT_W > 0) begin : g_ext
            assign prod_ext = {{EXT_W{prod[PROD_W-1]}}, prod};
        end else begin : g_noext
            assign prod_ext = prod[ACC_W-1:0];
        end
    endgenerate

    macc_addsub #(.ACC_W(ACC_W)) u_addsub (
        .acc      (acc_q),
        .prod_ext (prod_ext),
        .sub      (ctrl.sub),
        .sum      (sum_val)
    );

    macc_loadsel #(.ACC_W(ACC_W), .HAS_LOAD_MUX(HAS_LOAD_MUX)) u_sel (
        .load     (ctrl.load),
        .prod_ext (prod_ext),
        .sum      (sum_val),
        .next_val (next_val)
    );

    macc_accreg #(.ACC_W(ACC_W), .REG_KIND(REG_KIND)) u_reg (
        .clk (clk),
        .rst (rst),
        .en  (ctrl.en),
        .d   (next_val),
        .q   (acc_q)
    );

    generate
        if (COMB_TAP) begin : g_tap_comb
            assign result = next_val;
        end else begin : g_tap_reg
            assign result = acc_q;
        end
    endgenerate
endmodule

// File: rtl/macc_core_chk.sv
module macc_core_chk #(
    parameter int unsigned             OP_W         = macc_pkg::OP_W_DEF,
    parameter int unsigned             ACC_W        = macc_pkg::ACC_W_DEF,
    parameter bit                      HAS_LOAD_MUX = 1'b1,
    parameter macc_pkg::acc_reg_kind_e REG_KIND     = macc_pkg::REG_ARST_EN,
    parameter bit                      COMB_TAP     = 1'b0
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             load,
    input logic             sub,
    input logic [OP_W-1:0]  op_a,
    input logic [OP_W-1:0]  op_b,
    input logic [ACC_W-1:0] result,
    input logic [ACC_W-1:0] acc_q
);
    localparam int unsigned PROD_W = 2 * OP_W;
    localparam bit HR = macc_pkg::kind_has_rst(REG_KIND);
    localparam bit HE = macc_pkg::kind_has_en(REG_KIND);

    logic signed [PROD_W-1:0] p_s;
    logic [ACC_W-1:0]         p_x;
    logic                     go;
    logic                     acc_path;
    logic                     unused_sink;

    assign p_s         = $signed(op_a) * $signed(op_b);
    assign p_x         = ACC_W'(p_s);
    assign go          = en || !HE;
    assign acc_path    = !load || !HAS_LOAD_MUX;
    assign unused_sink = ^{result, sub, load, en};

    generate
        if (HR) begin : g_rst_props
            // R5
            rst_clear_chk: assert property (@(posedge clk) rst |-> acc_q == '0);

            // R2
            add_step_chk: assert property (@(posedge clk) disable iff (rst)
                (go && acc_path && !sub) |=> acc_q == $past(acc_q) + $past(p_x));

            // R3
            sub_step_chk: assert property (@(posedge clk) disable iff (rst)
                (go && acc_path && sub) |=> acc_q == $past(acc_q) - $past(p_x));

            if (HAS_LOAD_MUX) begin : g_load
                // R1
                load_prod_chk: assert property (@(posedge clk) disable iff (rst)
                    (go && load) |=> acc_q == $past(p_x));
            end

            if (HE) begin : g_hold
                // R6
                hold_en_chk: assert property (@(posedge clk) disable iff (rst)
                    !en |=> $stable(acc_q));
            end

            if (COMB_TAP) begin : g_comb
                // R8
                comb_tap_chk: assert property (@(posedge clk) disable iff (rst)
                    go |=> acc_q == $past(result));
            end else begin : g_reg
                // R7
                reg_tap_chk: assert property (@(posedge clk) disable iff (rst)
                    1'b1 |=> result == acc_q);
            end
        end
    endgenerate
endmodule

bind macc_core macc_core_chk #(
    .OP_W         (OP_W),
    .ACC_W        (ACC_W),
    .HAS_LOAD_MUX (HAS_LOAD_MUX),
    .REG_KIND     (REG_KIND),
    .COMB_TAP     (COMB_TAP)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .load   (load),
    .sub    (sub),
    .op_a   (op_a),
    .op_b   (op_b),
    .result (result),
    .acc_q  (acc_q)
);

// File: tb/macc_core_test.sv
`timescale 1ns/1ps
module macc_core_test;
    import macc_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        load = 1'b0;
    logic        sub = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic [39:0] res_main, res_comb, res_nomux, res_plain;

    logic [39:0] m_main = '0, m_nomux = '0, m_plain = '0;
    logic        plain_ok = 1'b0;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    macc_core #(.HAS_LOAD_MUX(1'b1), .REG_KIND(REG_ARST_EN), .COMB_TAP(1'b0)) uut (
        .clk(clk), .rst(rst), .en(en), .load(load), .sub(sub),
        .op_a(op_a), .op_b(op_b), .result(res_main));

    macc_core #(.HAS_LOAD_MUX(1'b1), .REG_KIND(REG_ARST_EN), .COMB_TAP(1'b1)) uut_comb (
        .clk(clk), .rst(rst), .en(en), .load(load), .sub(sub),
        .op_a(op_a), .op_b(op_b), .result(res_comb));

    macc_core #(.HAS_LOAD_MUX(1'b0), .REG_KIND(REG_ARST), .COMB_TAP(1'b0)) uut_nomux (
        .clk(clk), .rst(rst), .en(en), .load(load), .sub(sub),
        .op_a(op_a), .op_b(op_b), .result(res_nomux));

    macc_core #(.HAS_LOAD_MUX(1'b1), .REG_KIND(REG_PLAIN), .COMB_TAP(1'b0)) uut_plain (
        .clk(clk), .rst(rst), .en(en), .load(load), .sub(sub),
        .op_a(op_a), .op_b(op_b), .result(res_plain));

    function automatic logic [39:0] pext(input logic [15:0] a, input logic [15:0] b);
        logic signed [31:0] p;
        p = $signed(a) * $signed(b);
        return {{8{p[31]}}, p};
    endfunction

    task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock: drive, check combinational values, take the edge, check registers.
    task automatic cyc(input logic [15:0] a, input logic [15:0] b,
                       input logic ld, input logic sb, input logic e, input logic r,
                       input string tag);
        logic [39:0] p;
        logic [39:0] nx;
        op_a = a; op_b = b; load = ld; sub = sb; en = e; rst = r;
        #1;
        p = pext(a, b);
        if (r) begin
            m_main  = '0;
            m_nomux = '0;
            chk("R5 async clear uut", res_main, '0);
            chk("R5 async clear nomux", res_nomux, '0);
        end else begin
            chk("R7 registered tap between edges", res_main, m_main);
        end
        nx = ld ? p : (sb ? m_main - p : m_main + p);
        chk("R8 comb tap", res_comb, nx);
        @(posedge clk);
        if (!r && e) m_main = nx;
        if (!r) m_nomux = sb ? m_nomux - p : m_nomux + p;
        if (plain_ok || ld) begin
            m_plain  = ld ? p : (sb ? m_plain - p : m_plain + p);
            plain_ok = 1'b1;
        end
        #1;
        chk(tag, res_main, m_main);
        chk("R9 no load mux", res_nomux, m_nomux);
        if (plain_ok) chk("R10 plain register", res_plain, m_plain);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk("R5 reset state", res_main, '0);
        chk("R5 reset state nomux", res_nomux, '0);
        cyc(16'd0, 16'd0, 1'b0, 1'b0, 1'b1, 1'b0, "R5 after release");
    endtask

    task automatic t_load;
        cyc(16'd3, -16'sd7, 1'b1, 1'b0, 1'b1, 1'b0, "R1 load small");
        chk("R1 load -21", res_main, 40'hFF_FFFF_FFEB);
        cyc(16'h8000, 16'h8000, 1'b1, 1'b0, 1'b1, 1'b0, "R1 load max");
        chk("R1 load 2^30", res_main, 40'h00_4000_0000);
        cyc(16'h8000, 16'h7FFF, 1'b1, 1'b1, 1'b1, 1'b0, "R1 load neg");
    endtask

    task automatic t_add;
        cyc(16'd10, 16'd10, 1'b1, 1'b0, 1'b1, 1'b0, "R1 start");
        cyc(16'd1000, 16'd2000, 1'b0, 1'b0, 1'b1, 1'b0, "R2 add");
        cyc(-16'sd5, 16'd40, 1'b0, 1'b0, 1'b1, 1'b0, "R2 add negative");
        cyc(16'h7FFF, 16'h7FFF, 1'b0, 1'b0, 1'b1, 1'b0, "R2 add large");
        chk("R2 running sum", res_main, 40'd100 + 40'd2000000 - 40'd200 + 40'd1073676289);
    endtask

    task automatic t_sub;
        cyc(16'd4, 16'd4, 1'b1, 1'b0, 1'b1, 1'b0, "R1 start");
        cyc(16'd3, 16'd3, 1'b0, 1'b1, 1'b1, 1'b0, "R3 sub");
        cyc(16'd5, 16'd5, 1'b0, 1'b1, 1'b1, 1'b0, "R3 sub below zero");
        chk("R3 16-9-25", res_main, 40'hFF_FFFF_FFEE);
        cyc(-16'sd6, 16'd3, 1'b0, 1'b1, 1'b1, 1'b0, "R3 sub negative");
    endtask

    task automatic t_enable;
        cyc(16'd7, 16'd9, 1'b0, 1'b0, 1'b0, 1'b0, "R6 hold add");
        cyc(16'd2, 16'd2, 1'b1, 1'b0, 1'b0, 1'b0, "R6 hold load");
        cyc(16'd11, 16'd1, 1'b0, 1'b1, 1'b0, 1'b0, "R6 hold sub");
        cyc(16'd1, 16'd1, 1'b0, 1'b0, 1'b1, 1'b0, "R6 resume");
    endtask

    task automatic t_async;
        cyc(16'd9, 16'd9, 1'b0, 1'b0, 1'b0, 1'b1, "R5 held in reset");
        cyc(16'd2, 16'd3, 1'b0, 1'b0, 1'b1, 1'b0, "R5 accumulate from zero");
        chk("R5 first sum after clear", res_main, 40'd6);
    endtask

    task automatic t_wrap;
        cyc(16'h8000, 16'h8000, 1'b1, 1'b0, 1'b1, 1'b0, "R4 load 2^30");
        for (int i = 0; i < 511; i++) begin
            cyc(16'h8000, 16'h8000, 1'b0, 1'b0, 1'b1, 1'b0, "R4 climb");
        end
        chk("R4 reach 2^39", res_main, 40'h80_0000_0000);
        cyc(16'h8000, 16'h8000, 1'b0, 1'b0, 1'b1, 1'b0, "R4 past 2^39");
        chk("R4 wrapped", res_main, 40'h80_4000_0000);
        cyc(16'd0, 16'd5, 1'b1, 1'b0, 1'b1, 1'b0, "R4 load zero");
        cyc(16'd1, 16'd1, 1'b0, 1'b1, 1'b1, 1'b0, "R4 borrow");
        chk("R4 zero minus one", res_main, 40'hFF_FFFF_FFFF);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset;
        t_load;
        t_add;
        t_sub;
        t_enable;
        t_async;
        t_wrap;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule